// File: doc/BRIEF.md
# External Interrupt Edge/Level Detector

This block turns four maskable external interrupt pins and one non-maskable pin into request strobes for a downstream request-flag block. Each pin is asynchronous, so it first crosses a two-stage synchronizer. The block then compares the synchronized sample with the sample from the previous clock to find edges.

A single 8-bit write-only configuration register sets how each input is sensed. Each maskable input can be set to trigger on its rising or its falling edge. Input 0 can instead be switched to high-level sensing. The non-maskable input triggers on its falling edge, or on both edges.

In edge mode a request is a one-clock pulse. In level mode the input 0 request stays high for as long as the synchronized pin is high. Priority, vectoring and acknowledge are handled elsewhere.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is asserted and right after it, the configuration is all zeros and every request output is low.
- R2: Configuration bits 5, 4, 3 and 2 select the edge for inputs 3, 2, 1 and 0 respectively; 0 means rising and 1 means falling; a selected edge yields a request pulse exactly one clock long.
- R3: The clock edge that first samples a pin change counts as edge one. The resulting request is registered on the third clock edge.
- R4: With configuration bit 1 set to 1, the input 0 request is high on every cycle where the synchronized pin was high, with the same three-edge latency. It drops the same way when the pin goes low.
- R5: Configuration bit 0 controls the non-maskable input. With 0 it requests only on a falling edge. With 1 it requests on both edges, one pulse per edge.
- R6: An edge of the polarity that was not selected produces no request.
- R7: Writing the configuration while the pins are steady produces no request, even when the write inverts an edge selection.
- R8: Configuration bits 7 and 6 are reserved, and the values written to them have no effect on any request.
- R9: In level mode the edge-select bit of input 0 (bit 2) is ignored, and sensing is always active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| irq_pin | input | 4 | Asynchronous maskable interrupt pins |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_req | output | 4 | Per-input maskable request strobes |
| nmi_req | output | 1 | Non-maskable request strobe |

## Verification
The previous-sample register is the main internal state. If it is corrupted, a request appears on the third clock after a pin change or a configuration write, where none should be. If it is left stale, a request is lost on that same third clock.

A wrong configuration bit swaps which edge fires. In level mode it shows up as a request that lasts one cycle instead of following the pin. Each stimulus therefore checks the exact six-cycle request pattern that follows it, so a fault shows up within three clocks.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int NUM_IRQ = 4;
    localparam int NUM_SRC = NUM_IRQ + 1;
    localparam int NMI_IDX = NUM_IRQ;

    typedef struct packed {
        logic [1:0]         rsvd;
        logic [NUM_IRQ-1:0] fall_sel;
        logic               in0_level;
        logic               nmi_both;
    } cfg_t;

    localparam cfg_t CFG_RESET = '0;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg,
    input  logic [NUM_SRC-1:0] sync_s,
    output logic [NUM_IRQ-1:0] irq_req,
    output logic               nmi_req
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic [NUM_IRQ-1:0] irq;
        logic               nmi;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_SRC-1:0] rise, fall;

    always_comb begin
        rise = sync_s & ~st_q.prev;
        fall = ~sync_s & st_q.prev;
        // previous sample always tracks the synchronized input; a config
        // write never touches it, so re-selecting polarity cannot fake an edge
        st_d.prev = sync_s;
        for (int i = 0; i < NUM_IRQ; i++) begin
            st_d.irq[i] = cfg.fall_sel[i] ? fall[i] : rise[i];
        end
        if (cfg.in0_level) st_d.irq[0] = sync_s[0];
        st_d.nmi = cfg.nmi_both ? (rise[NMI_IDX] | fall[NMI_IDX]) : fall[NMI_IDX];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req = st_q.irq;
    assign nmi_req = st_q.nmi;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_wdata,
    input  logic [NUM_IRQ-1:0] irq_pin,
    input  logic               nmi_pin,
    output logic [NUM_IRQ-1:0] irq_req,
    output logic               nmi_req
);
    cfg_t cfg_d, cfg_q;
    logic [NUM_SRC-1:0] sync_s;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d      = cfg_t'(cfg_wdata);
            cfg_d.rsvd = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    ext_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({nmi_pin, irq_pin}),
        .sync_out (sync_s)
    );

    ext_irq_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg_q),
        .sync_s  (sync_s),
        .irq_req (irq_req),
        .nmi_req (nmi_req)
    );
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_q,
    input logic [4:0] sync_s,
    input logic [3:0] irq_req,
    input logic       nmi_req
);
    // R2: edge-only inputs give single-cycle pulses
    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req[3:1] != 3'b000) |=> ((irq_req[3:1] & $past(irq_req[3:1])) == 3'b000));

    // R5: non-maskable strobe is one cycle wide
    assert_nmi_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R7: no request on an edge-only input unless its synchronized sample changed
    assert_no_false_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[1] |-> ($past(sync_s[1]) != $past(sync_s[1], 2)));

    assert_nmi_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> ($past(sync_s[4]) != $past(sync_s[4], 2)));

    // R4: level mode follows the synchronized pin one register later
    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q[1]) |-> (irq_req[0] == $past(sync_s[0])));
endmodule

bind ext_irq_detect ext_irq_detect_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_q   (cfg_q),
    .sync_s  (sync_s),
    .irq_req (irq_req),
    .nmi_req (nmi_req)
);

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;
    localparam int WIN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [3:0] irq_pin = '0;
    logic       nmi_pin = 1'b0;
    logic [3:0] irq_req;
    logic       nmi_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_pin(irq_pin), .nmi_pin(nmi_pin), .irq_req(irq_req), .nmi_req(nmi_req)
    );

    // {cfg, source (4 = non-maskable), from, to, expected window mask}
    typedef struct packed {
        logic [7:0] cfg;
        logic [2:0] src;
        logic       from;
        logic       to;
        logic [5:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 3'd1, 1'b0, 1'b1, 6'b000100}, // R2 R3 rising on input 1
        '{8'h00, 3'd1, 1'b1, 1'b0, 6'b000000}, // R6
        '{8'h08, 3'd1, 1'b1, 1'b0, 6'b000100}, // R2 falling on input 1
        '{8'h08, 3'd1, 1'b0, 1'b1, 6'b000000}, // R6
        '{8'h00, 3'd0, 1'b0, 1'b1, 6'b000100}, // R2
        '{8'h04, 3'd0, 1'b1, 1'b0, 6'b000100}, // R2
        '{8'h04, 3'd0, 1'b0, 1'b1, 6'b000000}, // R6
        '{8'h10, 3'd2, 1'b1, 1'b0, 6'b000100}, // R2
        '{8'h00, 3'd2, 1'b0, 1'b1, 6'b000100}, // R2
        '{8'h20, 3'd3, 1'b1, 1'b0, 6'b000100}, // R2
        '{8'h00, 3'd3, 1'b1, 1'b0, 6'b000000}, // R6
        '{8'h02, 3'd0, 1'b0, 1'b1, 6'b111100}, // R4 level rise
        '{8'h02, 3'd0, 1'b1, 1'b0, 6'b000011}, // R4 level fall
        '{8'h06, 3'd0, 1'b0, 1'b1, 6'b111100}, // R9 edge bit ignored in level
        '{8'h00, 3'd4, 1'b1, 1'b0, 6'b000100}, // R5 falling only
        '{8'h00, 3'd4, 1'b0, 1'b1, 6'b000000}, // R5
        '{8'h01, 3'd4, 1'b0, 1'b1, 6'b000100}, // R5 both edges
        '{8'h01, 3'd4, 1'b1, 1'b0, 6'b000100}, // R5 both edges
        '{8'hC0, 3'd1, 1'b0, 1'b1, 6'b000100}, // R8 reserved bits set
        '{8'hC8, 3'd1, 1'b0, 1'b1, 6'b000000}  // R8
    };

    function automatic logic src_req(input int s);
        return (s == 4) ? nmi_req : irq_req[s];
    endfunction

    function automatic logic other_req(input int s);
        logic [4:0] all;
        all = {nmi_req, irq_req};
        all[s] = 1'b0;
        return |all;
    endfunction

    task automatic set_src(input int s, input logic v);
        @(negedge clk);
        if (s == 4) nmi_pin = v;
        else        irq_pin[s] = v;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        repeat (WIN) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic watch(input int s, output logic [5:0] mask, output logic stray);
        mask = '0;
        stray = 1'b0;
        for (int j = 0; j < WIN; j++) begin
            @(posedge clk);
            @(negedge clk);
            mask[j] = src_req(s);
            stray = stray | other_req(s);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] m;
        logic st;
        repeat (3) @(negedge clk);
        check("R1 reset irq", {27'd0, nmi_req, irq_req}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after reset", {27'd0, nmi_req, irq_req}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            write_cfg(VECS[v].cfg);
            set_src(int'(VECS[v].src), VECS[v].from);
            drain();
            set_src(int'(VECS[v].src), VECS[v].to);
            watch(int'(VECS[v].src), m, st);
            check($sformatf("R2/R3/R4/R5/R6/R8/R9 vector %0d mask", v), {26'd0, m}, {26'd0, VECS[v].exp});
            check($sformatf("vector %0d other sources quiet", v), {31'd0, st}, 32'd0);
            set_src(int'(VECS[v].src), 1'b0);
            drain();
        end

        // R7: polarity flip while pin 1 is held high must not fire
        write_cfg(8'h00);
        set_src(1, 1'b1);
        drain();
        write_cfg(8'h08);
        watch(1, m, st);
        check("R7 flip to falling", {26'd0, m}, 32'd0);
        write_cfg(8'h00);
        watch(1, m, st);
        check("R7 flip back to rising", {26'd0, m}, 32'd0);
        // R7: non-maskable both-edge enable while pin held low
        write_cfg(8'h01);
        watch(4, m, st);
        check("R7 nmi mode change", {26'd0, m}, 32'd0);
        set_src(1, 1'b0);
        drain();

        // R3: pulse stays one clock even with pin held for long
        write_cfg(8'h00);
        set_src(3, 1'b1);
        watch(3, m, st);
        check("R3 long hold single pulse", {26'd0, m}, 32'b000100);
        set_src(3, 1'b0);
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule